// File: doc/BRIEF.md
# Card Clock Generator

This block produces the card-side clock of an SD/MMC host controller from the host clock. A 16-bit control word sets three things. An 8-bit ratio code picks a power-of-two division from 2 up to 512. A run bit starts and stops the output. A pass-through bit routes the host clock to the card pin without division. Software writes the word over a simple write strobe and can read it back at any time. A soft-reset input from the surrounding controller keeps the card clock low until the controller leaves soft reset.

The divided clock comes from a counter, so every ratio has an exact 50 % duty cycle. A ratio written while the clock runs is picked up only at the start of a low phase. A half period is therefore never cut short. Clearing the run bit lets a high phase that is already under way finish, and then parks the output low.

Top module: `card_clk_gen`

## Requirements
- R1: After the asynchronous reset, the control readback is 0000h and the card clock stays low.
- R2: Bit 15 and bits 10..0 of the control word are stored and read back. Bits 14..11 always read 0. Writing 07FFh reads back 07FFh, and writing FFFFh reads back 87FFh.
- R3: With bit 8 (run) set and bit 15 clear, the ratio code in bits 7..0 selects the division. Code 00h divides by 2. A code with only bit i set divides by 2^(i+2), so 80h divides by 512. The high and low phases each last half the ratio in host clock cycles.
- R4: A ratio code with several bits set divides as if only its highest set bit were set. For example, 0Ch divides by 32 and 03h divides by 8.
- R5: With bit 15 and bit 8 both set, the card clock follows the host clock: high while the host clock is high, low while it is low. The ratio code has no effect.
- R6: With bit 8 clear, the card clock stays low. When bit 8 is cleared during a high phase, that high phase still lasts its full length, and the output then stays low.
- R7: A ratio written while the clock runs takes effect at the start of a low phase. The phases in progress finish at the old length, and every later low/high pair uses the new length.
- R8: While the soft-reset input is low, the card clock is held low, in divided and pass-through modes alike. The control word keeps its value. After release the clock resumes at the programmed ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk_i | input | 1 | Host clock, source of the card clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst_ni | input | 1 | Controller soft reset, 0 = in reset, 1 = released |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 16 | Control word to write |
| rd_data_o | output | 16 | Control word readback |
| card_clk_o | output | 1 | Clock driven to the card |

## Verification
The bench measures phase lengths in host clock cycles, so a counter that is off by one shows up as one-sided phases or a wrong period rather than going unnoticed. A wrong decode of the all-zero code, of the top code or of multi-bit codes gives a period that does not match the expected one. The ratio-change and stop tests start exactly at a phase boundary. A design that reloads the ratio mid-phase, or that drops the output as soon as run clears, produces a phase shorter than the expected length. The soft-reset and pass-through tests watch both host clock levels. They catch a gate that leaks pulses while in reset, or a divider that keeps toggling under pass-through.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  localparam int CTRL_W     = 16;
  localparam int BYPASS_BIT = 15;
  localparam int RUN_BIT    = 8;
  localparam logic [CTRL_W-1:0] STORE_MASK = 16'h87FF;
endpackage

// File: rtl/cardclk_ctrl_reg.sv
module cardclk_ctrl_reg
  import cardclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_ce;

  always_comb begin
    ctrl_ce = wr_en_i;
    ctrl_d  = wr_data_i & STORE_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/cardclk_ratio_dec.sv
module cardclk_ratio_dec #(
  parameter int CODE_W  = 8,
  parameter int SHIFT_W = $clog2(CODE_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CODE_W-1:0]  code_i,
  output logic [SHIFT_W-1:0] shift_o
);
  // Highest set bit wins; the all-zero code gives the smallest half period.
  always_comb begin
    shift_o = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (code_i[i]) shift_o = SHIFT_W'(i + 1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      assert_zero_code_R4: assert ((code_i == '0) == (shift_o == '0))
        else $error("zero code and zero shift disagree");
    end
  end
endmodule

// File: rtl/cardclk_div_core.sv
module cardclk_div_core #(
  parameter int CODE_W  = 8,
  parameter int SHIFT_W = $clog2(CODE_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               run_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               div_o
);
  localparam int CNT_W = CODE_W + 1;

  logic               div_q, div_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, lim;
  logic [SHIFT_W-1:0] shift_q, shift_d, shift_use;
  logic               load;

  always_comb begin
    // The ratio is only sampled on the first cycle of a low phase.
    load      = !div_q && (cnt_q == '0);
    shift_use = load ? shift_i : shift_q;
    lim       = (CNT_W'(1) << shift_use) - CNT_W'(1);
    shift_d   = shift_use;
    div_d     = div_q;
    cnt_d     = cnt_q;
    if (!enable_i) begin
      div_d = 1'b0;
      cnt_d = '0;
    end else if (!div_q && !run_i) begin
      cnt_d = '0;
    end else if (cnt_q == lim) begin
      div_d = !div_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
    end else begin
      div_q   <= div_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
    end
  end

  assign div_o = div_q;

  assert_parked_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_q && !run_i) |=> !div_q)
    else $error("divided clock rose while stopped");

  assert_ratio_frozen_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q && $past(div_q)) |-> $stable(shift_q))
    else $error("ratio changed inside a high phase");
endmodule

// File: rtl/cardclk_out_gate.sv
module cardclk_out_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pass_req_i,
  input  logic div_i,
  output logic card_clk_o
);
  logic pass_en_q;

  // Enable changes only while the host clock is low, so pass-through
  // never produces a runt pulse.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pass_en_q <= 1'b0;
    else         pass_en_q <= pass_req_i;
  end

  assign card_clk_o = (clk_i & pass_en_q) | div_i;
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import cardclk_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              hclk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic              card_clk_o
);
  localparam int SHIFT_W = $clog2(CODE_W + 1);

  logic [1:0]         rst_sync_q;
  logic               rst_n;
  logic [CTRL_W-1:0]  ctrl;
  logic [SHIFT_W-1:0] shift;
  logic               div_clk;
  logic               div_enable;
  logic               pass_req;

  always_ff @(posedge hclk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  cardclk_ctrl_reg i_reg (
    .clk_i     (hclk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl)
  );

  cardclk_ratio_dec #(.CODE_W(CODE_W), .SHIFT_W(SHIFT_W)) i_dec (
    .clk_i   (hclk_i),
    .rst_ni  (rst_n),
    .code_i  (ctrl[CODE_W-1:0]),
    .shift_o (shift)
  );

  always_comb begin
    div_enable = soft_rst_ni && !ctrl[BYPASS_BIT];
    pass_req   = soft_rst_ni && ctrl[BYPASS_BIT] && ctrl[RUN_BIT];
  end

  cardclk_div_core #(.CODE_W(CODE_W), .SHIFT_W(SHIFT_W)) i_div (
    .clk_i    (hclk_i),
    .rst_ni   (rst_n),
    .enable_i (div_enable),
    .run_i    (ctrl[RUN_BIT]),
    .shift_i  (shift),
    .div_o    (div_clk)
  );

  cardclk_out_gate i_gate (
    .clk_i      (hclk_i),
    .rst_ni     (rst_n),
    .pass_req_i (pass_req),
    .div_i      (div_clk),
    .card_clk_o (card_clk_o)
  );

  assign rd_data_o = ctrl;

  assert_pass_idles_divider_R5: assert property (@(posedge hclk_i) disable iff (!rst_n)
    ctrl[BYPASS_BIT] |=> !div_clk)
    else $error("divider toggled under pass-through");

  assert_soft_reset_low_R8: assert property (@(posedge hclk_i) disable iff (!rst_n)
    !soft_rst_ni |=> !div_clk)
    else $error("divided clock high during soft reset");
endmodule

// File: tb/test_card_clk_gen.sv
module test_card_clk_gen;
  logic        hclk;
  logic        rst_ni;
  logic        soft_rst_ni;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        card_clk;

  int vectors;
  int miscompares;

  card_clk_gen i_card_clk_gen (
    .hclk_i      (hclk),
    .rst_ni      (rst_ni),
    .soft_rst_ni (soft_rst_ni),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .card_clk_o  (card_clk)
  );

  initial hclk = 1'b0;
  always #2 hclk = ~hclk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge hclk);
    miscompares++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge hclk);
    #1;
  endtask

  task automatic reg_write(input logic [15:0] v);
    wr_en   = 1'b1;
    wr_data = v;
    @(posedge hclk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_level(input logic lv, input string req);
    int n;
    n = 0;
    while (card_clk !== lv && n < 2000) begin
      tick();
      n++;
    end
    if (n >= 2000) check(1'b0, req, n, 0);
  endtask

  task automatic run_len(input logic lv, output int n);
    n = 1;
    for (int i = 0; i < 2000; i++) begin
      tick();
      if (card_clk !== lv) break;
      n++;
    end
  endtask

  function automatic int half_of(input logic [7:0] code);
    int h;
    h = 1;
    for (int i = 0; i < 8; i++) if (code[i]) h = 1 << (i + 1);
    return h;
  endfunction

  task automatic measure_code(input logic [7:0] code, input string req);
    int a, b, hi, lo;
    reg_write(16'h0100 | {8'h00, code});
    tick();
    wait_level(1'b0, req);
    wait_level(1'b1, req);
    run_len(1'b1, a);
    run_len(1'b0, b);
    run_len(1'b1, hi);
    run_len(1'b0, lo);
    check(hi == half_of(code), req, hi, half_of(code));
    check(lo == half_of(code), req, lo, half_of(code));
  endtask

  task automatic t_reset();
    bit low_ok;
    low_ok = 1'b1;
    tick();
    check(rd_data == 16'h0000, "R1 readback", rd_data, 0);
    for (int i = 0; i < 20; i++) begin
      tick();
      if (card_clk !== 1'b0) low_ok = 1'b0;
    end
    check(low_ok, "R1 clock low", low_ok, 1);
  endtask

  task automatic t_register();
    reg_write(16'h07FF);
    tick();
    check(rd_data == 16'h07FF, "R2 07FF", rd_data, 16'h07FF);
    reg_write(16'hFFFF);
    tick();
    check(rd_data == 16'h87FF, "R2 FFFF", rd_data, 16'h87FF);
    reg_write(16'h0000);
    repeat (600) tick();
  endtask

  task automatic t_idle_without_run();
    bit low_ok;
    low_ok = 1'b1;
    reg_write(16'h0004);
    for (int i = 0; i < 60; i++) begin
      tick();
      if (card_clk !== 1'b0) low_ok = 1'b0;
    end
    check(low_ok, "R6 no run bit", low_ok, 1);
  endtask

  task automatic t_ratios();
    measure_code(8'h00, "R3 code 00");
    for (int i = 0; i < 8; i++) measure_code(8'(1 << i), "R3 one-hot code");
  endtask

  task automatic t_multibit();
    measure_code(8'h0C, "R4 code 0C");
    measure_code(8'h03, "R4 code 03");
    measure_code(8'h41, "R4 code 41");
  endtask

  task automatic t_pass_through();
    int bad_hi, bad_lo;
    bad_hi = 0;
    bad_lo = 0;
    reg_write(16'h8180);
    repeat (4) tick();
    for (int i = 0; i < 16; i++) begin
      @(posedge hclk);
      #1;
      if (card_clk !== 1'b1) bad_hi++;
      tick();
      if (card_clk !== 1'b0) bad_lo++;
    end
    check(bad_hi == 0, "R5 high with host clock", bad_hi, 0);
    check(bad_lo == 0, "R5 low with host clock", bad_lo, 0);
    reg_write(16'h0000);
    repeat (4) tick();
  endtask

  task automatic t_stop();
    int hi;
    bit low_ok;
    low_ok = 1'b1;
    measure_code(8'h04, "R3 code 04 before stop");
    wait_level(1'b0, "R6");
    wait_level(1'b1, "R6");
    reg_write(16'h0004);
    run_len(1'b1, hi);
    check(hi == 8, "R6 high phase completes", hi, 8);
    for (int i = 0; i < 40; i++) begin
      tick();
      if (card_clk !== 1'b0) low_ok = 1'b0;
    end
    check(low_ok, "R6 parked low", low_ok, 1);
  endtask

  task automatic t_change();
    int hi0, l1, h1, l2, h2;
    measure_code(8'h02, "R3 code 02 before change");
    wait_level(1'b0, "R7");
    wait_level(1'b1, "R7");
    run_len(1'b1, hi0);
    reg_write(16'h0108);
    run_len(1'b0, l1);
    run_len(1'b1, h1);
    run_len(1'b0, l2);
    run_len(1'b1, h2);
    check(l1 == 4, "R7 current low keeps old length", l1, 4);
    check(h1 == 4, "R7 following high keeps old length", h1, 4);
    check(l2 == 16, "R7 new low length", l2, 16);
    check(h2 == 16, "R7 new high length", h2, 16);
    measure_code(8'h01, "R7 shrink to code 01");
  endtask

  task automatic t_soft_reset();
    int a, hi, lo, bad;
    bit low_ok;
    low_ok = 1'b1;
    reg_write(16'h0101);
    repeat (10) tick();
    soft_rst_ni = 1'b0;
    repeat (2) tick();
    for (int i = 0; i < 30; i++) begin
      tick();
      if (card_clk !== 1'b0) low_ok = 1'b0;
    end
    check(low_ok, "R8 divided clock held low", low_ok, 1);
    check(rd_data == 16'h0101, "R8 control kept", rd_data, 16'h0101);
    reg_write(16'h8101);
    bad = 0;
    repeat (2) tick();
    for (int i = 0; i < 16; i++) begin
      @(posedge hclk);
      #1;
      if (card_clk !== 1'b0) bad++;
      tick();
      if (card_clk !== 1'b0) bad++;
    end
    check(bad == 0, "R8 pass-through held low", bad, 0);
    reg_write(16'h0101);
    tick();
    soft_rst_ni = 1'b1;
    wait_level(1'b1, "R8 resume");
    run_len(1'b1, a);
    run_len(1'b0, lo);
    run_len(1'b1, hi);
    check(lo == 2, "R8 resumed low", lo, 2);
    check(hi == 2, "R8 resumed high", hi, 2);
  endtask

  initial begin
    vectors     = 0;
    miscompares = 0;
    rst_ni      = 1'b0;
    soft_rst_ni = 1'b1;
    wr_en       = 1'b0;
    wr_data     = '0;
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (4) tick();
    t_reset();
    t_register();
    t_idle_without_run();
    t_ratios();
    t_multibit();
    t_pass_through();
    t_stop();
    t_change();
    t_soft_reset();
    summary();
    $finish;
  end
endmodule